// File: doc/BRIEF.md
# Display Driver Bus Write Master

This block is the host-side engine that moves single command or display-data bytes to a dot-matrix display driver. User logic offers one byte per request. Each request carries a data/command flag and a read flag. The engine accepts the request on a ready/valid handshake and answers with a one-cycle done pulse. For a read, the captured byte comes back with that pulse.

Two static inputs choose the pin protocol:

- **Parallel, 6800 style.** An active-high enable strobe is used, and a read/write level sets the direction.
- **Parallel, 8080 style.** Separate active-low read and write strobes are used.
- **Serial, write-only.** The bus uses data bit 7 as serial data and data bit 6 as serial clock. The other data pins are parked high.

The engine sequences chip select, the data/command line and the strobes with setup, strobe and hold phases. Each phase length is a parameter counted in system clocks.

The bidirectional data bus is exposed as three signals: an output byte, an output-enable, and an input byte. The pad ring combines them into an inout. The bus is released (output-enable low) whenever no write is in progress, and it stays released throughout a parallel read.

Top module: `lcd_bus_master`

## Requirements
- R1: After reset, `cs_no` is high, `db_oe_o` is low, `req_ready_o` is high, and `done_o`, `err_o` and `rd_data_o` are zero.
- R2: A request is accepted in a cycle where both `req_valid_i` and `req_ready_o` are high. `req_ready_o` stays low from acceptance until the done cycle. Request inputs presented while `req_ready_o` is low are ignored.
- R3: 8080 parallel write (`par_mode_i`=1, `m68_mode_i`=0) runs for the T_SETUP+T_PULSE+T_HOLD cycles after acceptance. Throughout, `cs_no` is 0 and the byte is driven with `db_oe_o`=1. `wr_rw_o` (write strobe) is low only for the T_PULSE cycles that follow T_SETUP, and `rd_e_o` stays high.
- R4: 6800 parallel write (`m68_mode_i`=1) uses the same phase lengths as R3. `wr_rw_o` (R/W level) is 0 for the whole transfer, and `rd_e_o` (enable) is high only during the T_PULSE cycles.
- R5: During a parallel read, `db_oe_o` stays 0 for the whole transfer. In 8080 style the strobe is `rd_e_o` low. In 6800 style the strobe is `rd_e_o` high, with `wr_rw_o` high for the whole transfer. `rd_data_o` takes the value that `db_i` held in the final strobe cycle and presents it in the done cycle.
- R6: `dc_o` equals the request's `req_dc_i` (1 for display data, 0 for a command) and stays unchanged while `cs_no` is low.
- R7: Serial write (`par_mode_i`=0) sends 8 bits MSB first on `db_o[7]`. For each bit, `db_o[6]` is low for T_SETUP cycles and then high for T_PULSE cycles. T_HOLD cycles with the clock low follow the last bit. Throughout, `db_o[5:0]` is 6'b111111, `db_oe_o`=1, and both `rd_e_o` and `wr_rw_o` are high.
- R8: A read request in serial mode is accepted and rejected. In the next cycle `err_o` and `done_o` pulse together. `cs_no` stays high and `db_oe_o` stays low.
- R9: When no transfer is in progress, the idle pins depend on the mode:
  - 8080 style: `cs_no`=1, `db_oe_o`=0, `rd_e_o`=1, `wr_rw_o`=1.
  - 6800 style: `rd_e_o`=0, `wr_rw_o`=1.
  - Serial: both strobes high.
- R10: `done_o` is high for exactly one cycle, the cycle after the last hold cycle. In that cycle `cs_no` is high and `req_ready_o` is high again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| par_mode_i | input | 1 | 1: parallel bus, 0: serial write-only link (static) |
| m68_mode_i | input | 1 | 1: 6800-style, 0: 8080-style parallel signalling (static) |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Engine can accept a request |
| req_dc_i | input | 1 | 1: display data, 0: command |
| req_rd_i | input | 1 | 1: read, 0: write |
| req_data_i | input | 8 | Byte to write |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | One-cycle pulse for a rejected serial read |
| rd_data_o | output | 8 | Last byte read from the driver |
| cs_no | output | 1 | Active-low chip select |
| dc_o | output | 1 | Data/command line |
| rd_e_o | output | 1 | 8080 read strobe (active low) or 6800 enable (active high) |
| wr_rw_o | output | 1 | 8080 write strobe (active low) or 6800 R/W level |
| db_o | output | 8 | Data bus output value |
| db_oe_o | output | 1 | Data bus output enable |
| db_i | input | 8 | Data bus input value |

## Verification
The checker enforces the following properties on every cycle:

- The bus is released whenever chip select is high.
- `req_ready_o` stays low while chip select is low.
- The data/command line holds steady throughout a transfer.
- The 8080 strobes are never low together.
- The bus is released while the 8080 read strobe is low.
- The 6800 enable is high only under chip select.
- Serial transfers park `db_o[5:0]` high and hold both strobes high.
- A serial read is followed by the err/done pulse.

Only the directed scenarios can show the rest:

- The exact phase lengths of each transfer.
- MSB-first serial bit order.
- That read data is taken from the final strobe cycle and not from another cycle.
- That a request held during a transfer leaves the bus byte untouched.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
  localparam int DW = 8;

  typedef struct packed {
    logic          cs_n;
    logic          dc;
    logic          rd_e;
    logic          wr_rw;
    logic          oe;
    logic [DW-1:0] dout;
  } pins_t;

  typedef enum logic [1:0] {P_IDLE, P_SETUP, P_STROBE, P_HOLD} par_st_e;
  typedef enum logic [1:0] {S_IDLE, S_LOW, S_HIGH, S_HOLD} ser_st_e;
endpackage

// File: rtl/lcd_par_engine.sv
module lcd_par_engine
  import lcd_bus_pkg::*;
#(
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_PULSE = 3,
  parameter int unsigned T_HOLD  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          m68_i,
  input  logic          start_i,
  input  logic          dc_i,
  input  logic          rd_i,
  input  logic [DW-1:0] data_i,
  input  logic [DW-1:0] db_i,
  output logic          busy_o,
  output logic          fin_o,
  output pins_t         pins_o,
  output logic [DW-1:0] rd_data_o
);
  localparam int unsigned TM0  = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int unsigned TMAX = (TM0 > T_HOLD) ? TM0 : T_HOLD;
  localparam int CW = (TMAX < 2) ? 1 : $clog2(TMAX);

  par_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic          dc_q, rd_q;
  logic [DW-1:0] byte_q;
  logic          last, strobe;

  assign last   = (cnt_q == '0);
  assign strobe = (st_q == P_STROBE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= P_IDLE;
      cnt_q     <= '0;
      dc_q      <= 1'b0;
      rd_q      <= 1'b0;
      byte_q    <= '0;
      rd_data_o <= '0;
    end else begin
      unique case (st_q)
        P_IDLE: if (start_i) begin
          st_q   <= P_SETUP;
          cnt_q  <= CW'(T_SETUP - 1);
          dc_q   <= dc_i;
          rd_q   <= rd_i;
          byte_q <= data_i;
        end
        P_SETUP: if (last) begin
          st_q  <= P_STROBE;
          cnt_q <= CW'(T_PULSE - 1);
        end else cnt_q <= cnt_q - 1'b1;
        P_STROBE: if (last) begin
          st_q  <= P_HOLD;
          cnt_q <= CW'(T_HOLD - 1);
          if (rd_q) rd_data_o <= db_i;  // value of final strobe cycle
        end else cnt_q <= cnt_q - 1'b1;
        P_HOLD: if (last) st_q <= P_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: st_q <= P_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != P_IDLE);
  assign fin_o  = (st_q == P_HOLD) && last;

  always_comb begin
    pins_o.cs_n = 1'b0;
    pins_o.dc   = dc_q;
    pins_o.oe   = !rd_q;
    pins_o.dout = byte_q;
    if (m68_i) begin
      pins_o.rd_e  = strobe;
      pins_o.wr_rw = rd_q;
    end else begin
      pins_o.rd_e  = !(strobe && rd_q);
      pins_o.wr_rw = !(strobe && !rd_q);
    end
  end
endmodule

// File: rtl/lcd_ser_engine.sv
module lcd_ser_engine
  import lcd_bus_pkg::*;
#(
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_PULSE = 3,
  parameter int unsigned T_HOLD  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          dc_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          fin_o,
  output pins_t         pins_o
);
  localparam int unsigned TM0  = (T_SETUP > T_PULSE) ? T_SETUP : T_PULSE;
  localparam int unsigned TMAX = (TM0 > T_HOLD) ? TM0 : T_HOLD;
  localparam int CW = (TMAX < 2) ? 1 : $clog2(TMAX);
  localparam int BW = $clog2(DW);

  ser_st_e       st_q;
  logic [CW-1:0] cnt_q;
  logic [BW-1:0] bit_q;
  logic          dc_q;
  logic [DW-1:0] sh_q;
  logic          last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
      bit_q <= '0;
      dc_q  <= 1'b0;
      sh_q  <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start_i) begin
          st_q  <= S_LOW;
          cnt_q <= CW'(T_SETUP - 1);
          bit_q <= BW'(DW - 1);
          dc_q  <= dc_i;
          sh_q  <= data_i;
        end
        S_LOW: if (last) begin
          st_q  <= S_HIGH;
          cnt_q <= CW'(T_PULSE - 1);
        end else cnt_q <= cnt_q - 1'b1;
        S_HIGH: if (last) begin
          if (bit_q == '0) begin
            st_q  <= S_HOLD;
            cnt_q <= CW'(T_HOLD - 1);
          end else begin
            st_q  <= S_LOW;
            cnt_q <= CW'(T_SETUP - 1);
            bit_q <= bit_q - 1'b1;
            sh_q  <= {sh_q[DW-2:0], 1'b0};
          end
        end else cnt_q <= cnt_q - 1'b1;
        S_HOLD: if (last) st_q <= S_IDLE;
                else cnt_q <= cnt_q - 1'b1;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q != S_IDLE);
  assign fin_o  = (st_q == S_HOLD) && last;

  always_comb begin
    pins_o.cs_n  = 1'b0;
    pins_o.dc    = dc_q;
    pins_o.rd_e  = 1'b1;
    pins_o.wr_rw = 1'b1;
    pins_o.oe    = 1'b1;
    pins_o.dout  = {sh_q[DW-1], (st_q == S_HIGH), {(DW-2){1'b1}}};
  end
endmodule

// File: rtl/lcd_bus_master.sv
module lcd_bus_master
  import lcd_bus_pkg::*;
#(
  parameter int unsigned T_SETUP = 2,
  parameter int unsigned T_PULSE = 3,
  parameter int unsigned T_HOLD  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          par_mode_i,
  input  logic          m68_mode_i,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_dc_i,
  input  logic          req_rd_i,
  input  logic [DW-1:0] req_data_i,
  output logic          done_o,
  output logic          err_o,
  output logic [DW-1:0] rd_data_o,
  output logic          cs_no,
  output logic          dc_o,
  output logic          rd_e_o,
  output logic          wr_rw_o,
  output logic [DW-1:0] db_o,
  output logic          db_oe_o,
  input  logic [DW-1:0] db_i
);
  logic  busy_q, done_q, err_q;
  logic  acc, rej, start_par, start_ser;
  logic  par_busy, par_fin, ser_busy, ser_fin;
  pins_t par_pins, ser_pins, idle_pins, pins;

  assign req_ready_o = !busy_q;
  assign acc       = req_valid_i && !busy_q;
  assign rej       = acc && !par_mode_i && req_rd_i;
  assign start_par = acc && par_mode_i;
  assign start_ser = acc && !par_mode_i && !req_rd_i;

  lcd_par_engine #(.T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) u_par (
    .clk_i, .rst_ni, .m68_i(m68_mode_i), .start_i(start_par),
    .dc_i(req_dc_i), .rd_i(req_rd_i), .data_i(req_data_i), .db_i,
    .busy_o(par_busy), .fin_o(par_fin), .pins_o(par_pins), .rd_data_o
  );

  lcd_ser_engine #(.T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)) u_ser (
    .clk_i, .rst_ni, .start_i(start_ser), .dc_i(req_dc_i), .data_i(req_data_i),
    .busy_o(ser_busy), .fin_o(ser_fin), .pins_o(ser_pins)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (start_par || start_ser) busy_q <= 1'b1;
      else if (par_fin || ser_fin) busy_q <= 1'b0;
      done_q <= par_fin || ser_fin || rej;
      err_q  <= rej;
    end
  end

  always_comb begin
    idle_pins.cs_n  = 1'b1;
    idle_pins.dc    = 1'b0;
    idle_pins.oe    = 1'b0;
    idle_pins.dout  = '0;
    idle_pins.rd_e  = !(par_mode_i && m68_mode_i);
    idle_pins.wr_rw = 1'b1;
    if (par_busy)      pins = par_pins;
    else if (ser_busy) pins = ser_pins;
    else               pins = idle_pins;
  end

  assign cs_no   = pins.cs_n;
  assign dc_o    = pins.dc;
  assign rd_e_o  = pins.rd_e;
  assign wr_rw_o = pins.wr_rw;
  assign db_oe_o = pins.oe;
  assign db_o    = pins.dout;
  assign done_o  = done_q;
  assign err_o   = err_q;
endmodule

// File: rtl/lcd_bus_master_chk.sv
module lcd_bus_master_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       par_mode_i,
  input logic       m68_mode_i,
  input logic       req_valid_i,
  input logic       req_rd_i,
  input logic       req_ready_o,
  input logic       done_o,
  input logic       err_o,
  input logic       cs_no,
  input logic       dc_o,
  input logic       rd_e_o,
  input logic       wr_rw_o,
  input logic       db_oe_o,
  input logic [7:0] db_o
);
  a_r9_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> !db_oe_o);
  a_r2_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> !req_ready_o);
  a_r6_dc_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !$past(cs_no)) |-> $stable(dc_o));
  a_r7_park: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && !par_mode_i) |-> (db_o[5:0] == 6'h3F && rd_e_o && wr_rw_o));
  a_r5_turnaround: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_no && par_mode_i && !m68_mode_i && !rd_e_o) |-> !db_oe_o);
  a_r3_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_mode_i && !m68_mode_i) |-> (rd_e_o || wr_rw_o));
  a_r4_enable_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_mode_i && m68_mode_i && rd_e_o) |-> !cs_no);
  a_r8_reject: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o && !par_mode_i && req_rd_i) |=> (err_o && done_o && cs_no));
  a_r10_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (cs_no && req_ready_o));
  a_r8_err_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
endmodule

bind lcd_bus_master lcd_bus_master_chk chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .par_mode_i(par_mode_i), .m68_mode_i(m68_mode_i),
  .req_valid_i(req_valid_i), .req_rd_i(req_rd_i), .req_ready_o(req_ready_o),
  .done_o(done_o), .err_o(err_o), .cs_no(cs_no), .dc_o(dc_o), .rd_e_o(rd_e_o),
  .wr_rw_o(wr_rw_o), .db_oe_o(db_oe_o), .db_o(db_o)
);

// File: tb/lcd_bus_master_tb.sv
module lcd_bus_master_tb_top;
  localparam int S = 2, P = 3, H = 1;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       par_mode = 1'b1, m68_mode = 1'b0;
  logic       req_valid = 1'b0, req_dc = 1'b0, req_rd = 1'b0;
  logic [7:0] req_data = '0, db_in = '0;
  logic       req_ready, done, err, cs_n, dc, rd_e, wr_rw, db_oe;
  logic [7:0] rd_data, db_out;
  int tests = 0, errs = 0;

  always #10 clk = ~clk;

  lcd_bus_master #(.T_SETUP(S), .T_PULSE(P), .T_HOLD(H)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .par_mode_i(par_mode), .m68_mode_i(m68_mode),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_dc_i(req_dc),
    .req_rd_i(req_rd), .req_data_i(req_data), .done_o(done), .err_o(err),
    .rd_data_o(rd_data), .cs_no(cs_n), .dc_o(dc), .rd_e_o(rd_e), .wr_rw_o(wr_rw),
    .db_o(db_out), .db_oe_o(db_oe), .db_i(db_in)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      errs++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // control vector {cs_n, dc, rd_e, wr_rw, oe, done, ready}
  function automatic logic [6:0] ctl();
    return {cs_n, dc, rd_e, wr_rw, db_oe, done, req_ready};
  endfunction

  task automatic t_idle(input string req, input logic rd_idle);
    @(negedge clk);
    chk({cs_n, db_oe, rd_e, wr_rw} == {1'b1, 1'b0, rd_idle, 1'b1}, req,
        {cs_n, db_oe, rd_e, wr_rw}, {1'b1, 1'b0, rd_idle, 1'b1});
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({cs_n, db_oe, req_ready, done, err} == 5'b10100, "R1 reset pins",
        {cs_n, db_oe, req_ready, done, err}, 5'b10100);
    chk(rd_data == 8'h00, "R1 reset rd_data", rd_data, 0);
  endtask

  // parallel transfer; tag names the requirement under test
  task automatic t_par(input string tag, input logic d, input logic r,
                       input logic [7:0] b, input logic [7:0] rv, input bit hold_valid);
    int n = S + P + H;
    bit ok_ctl = 1, ok_dat = 1;
    logic [6:0] exp, bad_act = '0, bad_exp = '0;
    logic [7:0] bad_dat = '0;
    @(negedge clk);
    req_valid = 1; req_dc = d; req_rd = r; req_data = b;
    @(posedge clk);
    for (int k = 0; k <= n; k++) begin
      @(negedge clk);
      if (k == 0 && hold_valid) begin req_data = ~b; req_dc = ~d; req_rd = ~r; end
      if (k == 0 && !hold_valid) req_valid = 0;
      if (k == n) req_valid = 0;
      db_in = (k == S + P - 1) ? rv : ~rv;
      if (k < n) begin
        logic act = (k >= S) && (k < S + P);
        if (m68_mode) exp = {1'b0, d, act, r, !r, 1'b0, 1'b0};
        else          exp = {1'b0, d, !(act && r), !(act && !r), !r, 1'b0, 1'b0};
        if (!r && db_out != b) begin ok_dat = 0; bad_dat = db_out; end
      end else exp = {1'b1, 1'b0, !m68_mode, 1'b1, 1'b0, 1'b1, 1'b1};
      if (ctl() != exp && ok_ctl) begin ok_ctl = 0; bad_act = ctl(); bad_exp = exp; end
      if (k == n && r) chk(rd_data == rv, {tag, " read data"}, rd_data, rv);
    end
    chk(ok_ctl, {tag, " R6 R10 pin sequence"}, bad_act, bad_exp);
    if (!r) chk(ok_dat, {tag, " bus byte"}, bad_dat, b);
    @(negedge clk);
    chk(done == 0, "R10 done single cycle", done, 0);
  endtask

  task automatic t_ser(input logic d, input logic [7:0] b);
    int n = 8 * (S + P) + H;
    bit ok = 1;
    logic [31:0] ba = '0, be = '0;
    @(negedge clk);
    req_valid = 1; req_dc = d; req_rd = 0; req_data = b;
    @(posedge clk);
    for (int k = 0; k <= n; k++) begin
      logic [15:0] exp, act;
      @(negedge clk);
      req_valid = 0;
      act = {ctl(), db_out, 1'b0};
      if (k < 8 * (S + P)) begin
        int bi = k / (S + P);
        logic hi = (k % (S + P)) >= S;
        exp = {1'b0, d, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, b[7 - bi], hi, 6'h3F, 1'b0};
      end else if (k < n)
        exp = {1'b0, d, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, b[0], 1'b0, 6'h3F, 1'b0};
      else begin
        exp = {1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 1'b0};
        act[8:1] = 8'h00;
      end
      if (act != exp && ok) begin ok = 0; ba = act; be = exp; end
    end
    chk(ok, "R7 R6 serial sequence", ba, be);
  endtask

  task automatic t_reject();
    @(negedge clk);
    req_valid = 1; req_dc = 1; req_rd = 1; req_data = 8'h5A;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk({err, done, cs_n, db_oe} == 4'b1110, "R8 reject pulse", {err, done, cs_n, db_oe}, 4'b1110);
    @(negedge clk);
    chk({err, done, cs_n, db_oe} == 4'b0010, "R8 reject clears", {err, done, cs_n, db_oe}, 4'b0010);
  endtask

  initial begin
    #(200000 * 20);
    tests++; errs++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  [TB] %0d tests run, %0d failed", tests, errs);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    rst_n = 1;
    t_idle("R9 idle 8080", 1'b1);
    t_par("R3 8080 write", 1'b1, 1'b0, 8'hC3, 8'h00, 0);
    t_par("R2 R3 8080 cmd held request", 1'b0, 1'b0, 8'h81, 8'h00, 1);
    t_par("R5 8080 read", 1'b1, 1'b1, 8'h00, 8'h6B, 0);
    m68_mode = 1;
    t_idle("R9 idle 6800", 1'b0);
    t_par("R4 6800 write", 1'b0, 1'b0, 8'h2E, 8'h00, 0);
    t_par("R5 6800 read", 1'b0, 1'b1, 8'h00, 8'hD4, 0);
    par_mode = 0;
    t_idle("R9 idle serial", 1'b1);
    t_ser(1'b1, 8'hA5);
    t_ser(1'b0, 8'h3C);
    t_reject();
    t_ser(1'b1, 8'h81);
    $display("  [TB] %0d tests run, %0d failed", tests, errs);
    $finish;
  end
endmodule